// File: doc/BRIEF.md
# Manchester II Frame Decoder

This block turns a recovered Manchester II half-bit stream into framed NRZ data. A line front end, outside this block, samples the line once per half-bit and presents each half-bit level with a one-cycle strobe. The decoder searches that stream continuously for a sync character, which is either a command sync or a data sync. It accepts a frame only when the sync is followed directly by two correctly coded Manchester bits.

Once a frame is accepted, the decoder delivers the K data bits, most significant first, on a serial NRZ output. It also produces a shift clock for an external shift register, raises take-data for the length of the delivery, and raises the flag for the sync type it received. After the data it checks the parity bit and any Manchester coding errors. It then reports the outcome on a valid-word flag, which stays high for a fixed time. The word length is programmable. A synchronous decoder reset abandons any frame in progress and returns the block to searching.

Top module: `mdec_frame_decoder`

## Requirements
- R1: Half-bit levels are taken on cycles with `half_valid_i` high. A command sync is three high halves followed by three low halves, and a data sync is three low halves followed by three high halves. A data bit of 1 is sent high-then-low and a bit of 0 low-then-high. `take_data_o` rises only on the strobe that completes the second valid bit after a sync. A sync followed by a bit whose two halves are equal is not accepted.
- R2: With `take_data_o`, exactly one of `cmd_sync_o` / `data_sync_o` rises, matching the received sync. It stays high for K rising edges of `shift_clk_o`, and the two flags are never high together.
- R3: `shift_clk_o` is low during the first half of each bit period and high during the second. While `take_data_o` is high, `sdo_o` carries the K data bits in the order received, is stable at each rising edge of `shift_clk_o`, and there are exactly K such edges.
- R4: K equals `len_i`, limited to the range 2..28: a value below 2 gives 2 and a value above 28 gives 28.
- R5: Parity is counted over the K data bits plus the parity bit that follows them. With `par_even_i` high the count of ones must be even, and with it low it must be odd. A parity mismatch keeps `valid_word_o` low.
- R6: A data or parity bit whose two halves are equal is a Manchester error. It keeps `valid_word_o` low for that frame, but the K bits are still delivered.
- R7: `valid_word_o` is low during reception. It rises, if the frame was clean, on the second half-bit strobe after the parity bit, on the same edge where `take_data_o` falls. It falls after exactly 2K+8 further half-bit strobes, which is K+4 bit periods.
- R8: While `valid_word_o` is high the search continues. Acceptance of a new frame clears `valid_word_o` at once.
- R9: `dec_reset_i` high on a clock edge clears `take_data_o`, both sync flags and `valid_word_o`. Only half-bits received after it count towards a new sync, so a full sync plus two bits must arrive before the next frame.
- R10: After `rst_ni` all outputs are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| half_valid_i | input | 1 | Strobe: a recovered half-bit level is present |
| half_i | input | 1 | Recovered half-bit level |
| len_i | input | 5 | Data bits per word (limited to 2..28) |
| par_even_i | input | 1 | 1 = even parity check, 0 = odd |
| dec_reset_i | input | 1 | Synchronous abort of reception |
| shift_clk_o | output | 1 | Bit-rate shift clock, rising mid-bit |
| sdo_o | output | 1 | Decoded NRZ data |
| take_data_o | output | 1 | High while decoded bits are delivered |
| cmd_sync_o | output | 1 | Frame began with a command sync |
| data_sync_o | output | 1 | Frame began with a data sync |
| valid_word_o | output | 1 | Last word had correct parity and coding |

## Verification
The assertions check, on every cycle, the following properties: the two sync flags are mutually exclusive and tied to take-data; take-data only rises on a half-bit strobe; the shift clock only moves on a strobe; serial data only changes while the shift clock is low; valid-word never overlaps take-data and rises only as take-data falls; and the decoder reset clears every flag. The bench scenarios cover the rest. These are the recovered bit values and their order, the count of shift edges per length including the clamped lengths, the parity sense, the effect of coding errors, the exact 2K+8 hold time, early clearing by a new frame, and rejection of a sync whose qualifying bits are badly coded.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  typedef enum logic [1:0] {
    RX_HUNT = 2'd0,
    RX_RECV = 2'd1,
    RX_TAIL = 2'd2
  } rx_state_e;

  typedef enum logic [1:0] {
    KIND_NONE = 2'd0,
    KIND_CMD  = 2'd1,
    KIND_DATA = 2'd2
  } sync_kind_e;
endpackage

// File: rtl/mdec_sync_hunt.sv
module mdec_sync_hunt
  import mdec_pkg::*;
#(
  parameter int SYNC_HALVES = 6,
  parameter int QUAL_BITS   = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 clr_i,
  input  logic                 half_valid_i,
  input  logic                 half_i,
  output logic                 hit_o,
  output sync_kind_e           kind_o,
  output logic [QUAL_BITS-1:0] bits_o
);
  localparam int WIN_W        = SYNC_HALVES + 2 * QUAL_BITS;
  localparam int FILL_W       = $clog2(WIN_W + 1);
  localparam int LEVEL_HALVES = SYNC_HALVES / 2;

  logic [WIN_W-1:0]       win_q, win_nxt;
  logic [FILL_W-1:0]      fill_q;
  logic [SYNC_HALVES-1:0] cmd_pat, sync_field;
  logic [QUAL_BITS-1:0]   qual_ok;
  logic                   full, is_cmd, is_data;

  assign win_nxt = {win_q[WIN_W-2:0], half_i};

  // oldest half sits at the top of the field
  for (genvar i = 0; i < SYNC_HALVES; i++) begin : g_pat
    assign cmd_pat[i] = (i >= SYNC_HALVES - LEVEL_HALVES);
  end

  for (genvar q = 0; q < QUAL_BITS; q++) begin : g_qual
    assign qual_ok[q] = win_nxt[2*q+1] ^ win_nxt[2*q];
    assign bits_o[q]  = win_nxt[2*q+1];
  end

  assign sync_field = win_nxt[WIN_W-1 -: SYNC_HALVES];
  assign full       = (fill_q >= FILL_W'(WIN_W - 1));
  assign is_cmd     = (sync_field == cmd_pat);
  assign is_data    = (sync_field == ~cmd_pat);
  assign hit_o      = half_valid_i & ~clr_i & full & (&qual_ok) & (is_cmd | is_data);
  assign kind_o     = is_cmd ? KIND_CMD : (is_data ? KIND_DATA : KIND_NONE);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (clr_i) begin
      win_q  <= '0;
      fill_q <= '0;
    end else if (half_valid_i) begin
      win_q <= win_nxt;
      if (fill_q != FILL_W'(WIN_W)) fill_q <= fill_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdec_frame_rx.sv
module mdec_frame_rx
  import mdec_pkg::*;
#(
  parameter int LEN_W     = 5,
  parameter int QUAL_BITS = 2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 abort_i,
  input  logic                 half_valid_i,
  input  logic                 half_i,
  input  logic                 hit_i,
  input  sync_kind_e           hit_kind_i,
  input  logic [QUAL_BITS-1:0] hit_bits_i,
  input  logic [LEN_W-1:0]     k_i,
  input  logic                 par_even_i,
  output logic                 take_o,
  output logic                 sdo_o,
  output logic                 shift_clk_o,
  output logic                 cmd_o,
  output logic                 data_o,
  output logic                 start_o,
  output logic                 done_o,
  output logic                 word_ok_o
);
  rx_state_e            state_q;
  logic                 phase_q, h0_q, sdo_q, take_q, cmd_q, data_q, par_q, err_q;
  logic [LEN_W-1:0]     rx_cnt_q;
  logic [QUAL_BITS-2:0] dly_q;
  logic [QUAL_BITS-1:0] dly_nxt;
  logic                 bit_end, bad_bit;

  assign bit_end   = half_valid_i & phase_q;
  assign bad_bit   = (h0_q == half_i);
  assign dly_nxt   = {dly_q, h0_q};
  assign start_o   = (state_q == RX_HUNT) & hit_i & ~abort_i;
  assign done_o    = (state_q == RX_TAIL) & bit_end & ~abort_i;
  assign word_ok_o = ~err_q & (par_q ^ par_even_i);

  assign take_o      = take_q;
  assign sdo_o       = sdo_q;
  assign shift_clk_o = phase_q;
  assign cmd_o       = cmd_q;
  assign data_o      = data_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= RX_HUNT;
      phase_q  <= 1'b0;
      h0_q     <= 1'b0;
      sdo_q    <= 1'b0;
      take_q   <= 1'b0;
      cmd_q    <= 1'b0;
      data_q   <= 1'b0;
      par_q    <= 1'b0;
      err_q    <= 1'b0;
      rx_cnt_q <= '0;
      dly_q    <= '0;
    end else if (abort_i) begin
      state_q <= RX_HUNT;
      phase_q <= 1'b0;
      take_q  <= 1'b0;
      cmd_q   <= 1'b0;
      data_q  <= 1'b0;
    end else begin
      unique case (state_q)
        RX_HUNT: begin
          if (start_o) begin
            state_q  <= RX_RECV;
            phase_q  <= 1'b0;
            take_q   <= 1'b1;
            cmd_q    <= (hit_kind_i == KIND_CMD);
            data_q   <= (hit_kind_i == KIND_DATA);
            sdo_q    <= hit_bits_i[QUAL_BITS-1];
            dly_q    <= hit_bits_i[QUAL_BITS-2:0];
            par_q    <= ^hit_bits_i;
            err_q    <= 1'b0;
            rx_cnt_q <= LEN_W'(QUAL_BITS);
          end else if (half_valid_i) begin
            phase_q <= ~phase_q;
          end
        end
        RX_RECV: begin
          if (half_valid_i) begin
            phase_q <= ~phase_q;
            if (!phase_q) begin
              h0_q <= half_i;
            end else begin
              err_q <= err_q | bad_bit;
              par_q <= par_q ^ h0_q;
              sdo_q <= dly_nxt[QUAL_BITS-1];
              dly_q <= dly_nxt[QUAL_BITS-2:0];
              // bit just closed is the parity bit once K data bits are in
              if (rx_cnt_q >= k_i) state_q <= RX_TAIL;
              else rx_cnt_q <= rx_cnt_q + 1'b1;
            end
          end
        end
        RX_TAIL: begin
          if (half_valid_i) begin
            phase_q <= ~phase_q;
            if (phase_q) begin
              state_q <= RX_HUNT;
              take_q  <= 1'b0;
              cmd_q   <= 1'b0;
              data_q  <= 1'b0;
            end
          end
        end
        default: state_q <= RX_HUNT;
      endcase
    end
  end
endmodule

// File: rtl/mdec_valid_hold.sv
module mdec_valid_hold #(
  parameter int LEN_W      = 5,
  parameter int HOLD_EXTRA = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             abort_i,
  input  logic             start_i,
  input  logic             done_i,
  input  logic             ok_i,
  input  logic             half_valid_i,
  input  logic [LEN_W-1:0] k_i,
  output logic             valid_o
);
  localparam int CNT_W = LEN_W + 3;

  logic [CNT_W-1:0] cnt_q, limit;
  logic             valid_q;

  // hold time in half-bit strobes: two per bit period
  assign limit   = CNT_W'({k_i, 1'b0}) + CNT_W'(2 * HOLD_EXTRA);
  assign valid_o = valid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (abort_i || start_i) begin
      valid_q <= 1'b0;
      cnt_q   <= '0;
    end else if (done_i) begin
      valid_q <= ok_i;
      cnt_q   <= '0;
    end else if (valid_q && half_valid_i) begin
      if (cnt_q == limit - 1'b1) valid_q <= 1'b0;
      else cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/mdec_frame_decoder.sv
module mdec_frame_decoder
  import mdec_pkg::*;
#(
  parameter int LEN_W       = 5,
  parameter int K_MIN       = 2,
  parameter int K_MAX       = 28,
  parameter int SYNC_HALVES = 6,
  parameter int QUAL_BITS   = 2,
  parameter int HOLD_EXTRA  = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             half_valid_i,
  input  logic             half_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic             par_even_i,
  input  logic             dec_reset_i,
  output logic             shift_clk_o,
  output logic             sdo_o,
  output logic             take_data_o,
  output logic             cmd_sync_o,
  output logic             data_sync_o,
  output logic             valid_word_o
);
  localparam logic [LEN_W-1:0] K_LO = LEN_W'(K_MIN);
  localparam logic [LEN_W-1:0] K_HI = LEN_W'(K_MAX);

  logic [LEN_W-1:0]     k_eff;
  logic                 hit, start, done, word_ok;
  sync_kind_e           hit_kind;
  logic [QUAL_BITS-1:0] hit_bits;

  always_comb begin
    if (len_i < K_LO)      k_eff = K_LO;
    else if (len_i > K_HI) k_eff = K_HI;
    else                   k_eff = len_i;
  end

  mdec_sync_hunt #(
    .SYNC_HALVES(SYNC_HALVES),
    .QUAL_BITS  (QUAL_BITS)
  ) u_hunt (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .clr_i       (dec_reset_i),
    .half_valid_i(half_valid_i),
    .half_i      (half_i),
    .hit_o       (hit),
    .kind_o      (hit_kind),
    .bits_o      (hit_bits)
  );

  mdec_frame_rx #(
    .LEN_W    (LEN_W),
    .QUAL_BITS(QUAL_BITS)
  ) u_rx (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (dec_reset_i),
    .half_valid_i(half_valid_i),
    .half_i      (half_i),
    .hit_i       (hit),
    .hit_kind_i  (hit_kind),
    .hit_bits_i  (hit_bits),
    .k_i         (k_eff),
    .par_even_i  (par_even_i),
    .take_o      (take_data_o),
    .sdo_o       (sdo_o),
    .shift_clk_o (shift_clk_o),
    .cmd_o       (cmd_sync_o),
    .data_o      (data_sync_o),
    .start_o     (start),
    .done_o      (done),
    .word_ok_o   (word_ok)
  );

  mdec_valid_hold #(
    .LEN_W     (LEN_W),
    .HOLD_EXTRA(HOLD_EXTRA)
  ) u_hold (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .abort_i     (dec_reset_i),
    .start_i     (start),
    .done_i      (done),
    .ok_i        (word_ok),
    .half_valid_i(half_valid_i),
    .k_i         (k_eff),
    .valid_o     (valid_word_o)
  );
endmodule

// File: rtl/mdec_frame_decoder_chk.sv
module mdec_frame_decoder_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic half_valid_i,
  input logic dec_reset_i,
  input logic shift_clk_o,
  input logic sdo_o,
  input logic take_data_o,
  input logic cmd_sync_o,
  input logic data_sync_o,
  input logic valid_word_o
);
  assert_take_on_strobe_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(take_data_o) |-> $past(half_valid_i));

  assert_one_flag_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({cmd_sync_o, data_sync_o}));

  assert_flag_with_take_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cmd_sync_o || data_sync_o) == take_data_o);

  assert_shift_on_strobe_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!half_valid_i && !dec_reset_i) |=> $stable(shift_clk_o));

  assert_sdo_moves_low_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (take_data_o && !$stable(sdo_o)) |-> !shift_clk_o);

  assert_valid_no_overlap_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(valid_word_o && take_data_o));

  assert_valid_rise_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(valid_word_o) |-> $fell(take_data_o));

  assert_abort_clears_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    dec_reset_i |=> (!take_data_o && !valid_word_o && !cmd_sync_o && !data_sync_o));
endmodule

bind mdec_frame_decoder mdec_frame_decoder_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .half_valid_i(half_valid_i),
  .dec_reset_i (dec_reset_i),
  .shift_clk_o (shift_clk_o),
  .sdo_o       (sdo_o),
  .take_data_o (take_data_o),
  .cmd_sync_o  (cmd_sync_o),
  .data_sync_o (data_sync_o),
  .valid_word_o(valid_word_o)
);

// File: tb/mdec_frame_decoder_tb.sv
module mdec_frame_decoder_tb;
  localparam int GAP = 2;

  typedef struct packed {
    logic        cmd;
    logic [4:0]  len;
    logic        par_even;
    logic        bad_par;
    logic [27:0] data;
  } vec_t;

  localparam int NVEC = 8;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 5'd16, 1'b1, 1'b0, 28'h000A5C3},
    '{1'b0, 5'd16, 1'b0, 1'b0, 28'h0000001},
    '{1'b1, 5'd2,  1'b1, 1'b0, 28'h0000002},
    '{1'b0, 5'd28, 1'b0, 1'b0, 28'hFFFFFFF},
    '{1'b1, 5'd0,  1'b0, 1'b1, 28'h0000001},
    '{1'b0, 5'd31, 1'b1, 1'b0, 28'h5A5A5A5},
    '{1'b1, 5'd7,  1'b0, 1'b1, 28'h0000055},
    '{1'b0, 5'd9,  1'b1, 1'b0, 28'h00001F0}
  };

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic half_valid_i = 1'b0;
  logic half_i = 1'b0;
  logic [4:0] len_i = 5'd16;
  logic par_even_i = 1'b1;
  logic dec_reset_i = 1'b0;
  logic shift_clk_o, sdo_o, take_data_o, cmd_sync_o, data_sync_o, valid_word_o;

  int n_checks = 0;
  int n_errors = 0;
  bit done = 1'b0;

  int cap_cnt = 0;
  int cmd_edges = 0;
  int data_edges = 0;
  logic [31:0] cap_word = '0;
  logic prev_sc = 1'b0;

  always #2 clk = ~clk;

  mdec_frame_decoder u_dut (
    .clk_i       (clk),
    .rst_ni      (rst_ni),
    .half_valid_i(half_valid_i),
    .half_i      (half_i),
    .len_i       (len_i),
    .par_even_i  (par_even_i),
    .dec_reset_i (dec_reset_i),
    .shift_clk_o (shift_clk_o),
    .sdo_o       (sdo_o),
    .take_data_o (take_data_o),
    .cmd_sync_o  (cmd_sync_o),
    .data_sync_o (data_sync_o),
    .valid_word_o(valid_word_o)
  );

  // capture what an external register would shift in on rising shift_clk_o
  always @(negedge clk) begin
    if (shift_clk_o && !prev_sc && take_data_o) begin
      cap_cnt  = cap_cnt + 1;
      cap_word = {cap_word[30:0], sdo_o};
      if (cmd_sync_o) cmd_edges = cmd_edges + 1;
      if (data_sync_o) data_edges = data_edges + 1;
    end
    prev_sc = shift_clk_o;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int kof(input int len);
    if (len < 2) return 2;
    if (len > 28) return 28;
    return len;
  endfunction

  task automatic send_half(input logic b);
    @(negedge clk);
    half_i = b;
    half_valid_i = 1'b1;
    @(negedge clk);
    half_valid_i = 1'b0;
    repeat (GAP) @(negedge clk);
  endtask

  task automatic send_bit(input logic b, input bit bad);
    send_half(b);
    send_half(bad ? b : ~b);
  endtask

  task automatic send_sync(input logic cmd);
    for (int i = 0; i < 3; i++) send_half(cmd);
    for (int i = 0; i < 3; i++) send_half(~cmd);
  endtask

  task automatic pulse_dec_reset();
    @(negedge clk);
    dec_reset_i = 1'b1;
    @(negedge clk);
    dec_reset_i = 1'b0;
    @(negedge clk);
  endtask

  task automatic run_frame(input logic cmd, input logic [4:0] len, input logic pe,
                           input logic bad_par, input logic [27:0] data, input int err_idx);
    int k, ones, c0, e0, d0;
    logic [31:0] m, d;
    logic p, exp_valid;
    k = kof(int'(len));
    m = (k == 32) ? 32'hFFFFFFFF : ((32'h1 << k) - 1);
    d = {4'h0, data} & m;
    ones = $countones(d);
    p = pe ? ones[0] : ~ones[0];
    if (bad_par) p = ~p;
    exp_valid = !bad_par && (err_idx < 0);
    len_i = len;
    par_even_i = pe;
    c0 = cap_cnt; e0 = cmd_edges; d0 = data_edges;
    send_sync(cmd);
    for (int i = k - 1; i >= 0; i--) send_bit(d[i], err_idx == i);
    send_bit(p, err_idx == k);
    send_half(1'b1);
    check("R7 valid low until frame end", 32'(valid_word_o), 32'h0);
    send_half(1'b0);
    check("R3 take low after frame", 32'(take_data_o), 32'h0);
    check("R4 shift edges equal clamped K", 32'(cap_cnt - c0), 32'(k));
    check("R3 delivered bits", cap_word & m, d);
    check("R2 command flag edges", 32'(cmd_edges - e0), cmd ? 32'(k) : 32'h0);
    check("R2 data flag edges", 32'(data_edges - d0), cmd ? 32'h0 : 32'(k));
    check(err_idx >= 0 ? "R6 valid word" : "R5 valid word", 32'(valid_word_o), 32'(exp_valid));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R10 reset take", 32'(take_data_o), 32'h0);
    check("R10 reset flags", 32'({cmd_sync_o, data_sync_o, valid_word_o, shift_clk_o}), 32'h0);
    rst_ni = 1'b1;
    @(negedge clk);

    for (int v = 0; v < NVEC; v++)
      run_frame(VECS[v].cmd, VECS[v].len, VECS[v].par_even, VECS[v].bad_par, VECS[v].data, -1);

    // R8: new frame clears valid early; R3 shift clock phase at start
    run_frame(1'b0, 5'd4, 1'b1, 1'b0, 28'h9, -1);
    send_sync(1'b1);
    send_bit(1'b1, 1'b0);
    send_half(1'b1);
    check("R8 valid still high before accept", 32'(valid_word_o), 32'h1);
    send_half(1'b0);
    check("R8 valid cleared on new frame", 32'(valid_word_o), 32'h0);
    check("R1 take on second bit end", 32'(take_data_o), 32'h1);
    check("R2 command flag", 32'({cmd_sync_o, data_sync_o}), 32'h2);
    check("R3 shift low in first half", 32'(shift_clk_o), 32'h0);
    send_half(1'b0);
    check("R3 shift high in second half", 32'(shift_clk_o), 32'h1);
    check("R3 first bit on sdo", 32'(sdo_o), 32'h1);

    // R9: abort mid-frame
    pulse_dec_reset();
    check("R9 abort clears take", 32'(take_data_o), 32'h0);
    check("R9 abort clears flags", 32'({cmd_sync_o, data_sync_o}), 32'h0);

    // R9: abort while valid is high, then a fresh frame is found
    run_frame(1'b1, 5'd6, 1'b0, 1'b0, 28'h2D, -1);
    pulse_dec_reset();
    check("R9 abort clears valid", 32'(valid_word_o), 32'h0);
    run_frame(1'b0, 5'd5, 1'b1, 1'b0, 28'h16, -1);

    // R1: sync followed by a badly coded bit is rejected
    send_sync(1'b1);
    send_bit(1'b1, 1'b1);
    send_bit(1'b0, 1'b0);
    check("R1 bad qualifier rejected", 32'(take_data_o), 32'h0);
    run_frame(1'b1, 5'd8, 1'b0, 1'b0, 28'hC3, -1);

    // R6: coding error in data and in parity bit
    run_frame(1'b0, 5'd8, 1'b1, 1'b0, 28'hA6, 3);
    run_frame(1'b1, 5'd3, 1'b1, 1'b0, 28'h5, 3);

    // R7: hold time of 2K+8 half-bit strobes, K=4
    run_frame(1'b1, 5'd4, 1'b0, 1'b0, 28'h6, -1);
    for (int i = 0; i < 15; i++) send_half(i % 2 == 0);
    check("R7 valid held 2K+7 strobes", 32'(valid_word_o), 32'h1);
    send_half(1'b1);
    check("R7 valid falls at 2K+8 strobes", 32'(valid_word_o), 32'h0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_errors++;
      $display("FAIL watchdog R1 actual=hung expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
      $finish;
    end
  end
endmodule